// File: doc/BRIEF.md
# Local Interrupt Source Dispatcher

This block takes event pulses from six local interrupt sources inside a processor's interrupt controller (a countdown timer, a thermal monitor, a performance counter, two external local pins and an internal error detector) and converts each event into a vector request for the interrupt request logic. Each source owns a 32-bit routing entry. The entry holds an 8-bit vector, a 3-bit delivery-mode code and a mask bit. Software writes and reads the entries through a simple register port.

An event from a masked source is dropped. An event from an unmasked source is held pending until the dispatcher serves it. The dispatcher serves one source per cycle, and the lowest source index wins. If the effective delivery mode of the served source is fixed, the block emits a one-cycle request carrying the vector and the source index. If the mode is anything else, the block emits a one-cycle unsupported-mode strobe instead. The timer and error sources always count as fixed, whatever their mode field holds.

Top module: `lvec_dispatch`

## Requirements
- R1: After reset every entry reads 0x00010000 (masked, mode 0, vector 0). Neither `req_valid` nor `err_mode` is asserted.
- R2: Entries sit at byte offsets 0x320 + 0x10*i. The source indices i are timer=0, thermal=1, perf=2, pin0=3, pin1=4, error=5. Field layout: vector in bits [7:0], mode in bits [10:8], mask in bit 16. All other bits read as 0. A read of any other address returns 0. A write to any other address changes no entry.
- R3: A pulse from a source whose mask bit is 1 produces neither a request nor a strobe.
- R4: An unmasked pulse whose effective mode is fixed (code 0) gives `req_valid` high for one cycle. This happens in the cycle after the clock edge that samples the pulse, with `req_vec` set to the entry's vector and `req_src` set to the source index.
- R5: For sources 1 to 4, an unmasked pulse with a mode other than 0 gives `err_mode` high for one cycle, with `err_src` set to the source index, and no request.
- R6: Sources 0 and 5 always deliver a request, whatever their mode field holds.
- R7: When pulses from several sources are pending together, they are served on consecutive cycles in ascending index order (timer first, error last), one per cycle.
- R8: In any cycle at most one of `req_valid` and `err_mode` is high.
- R9: A pulse on a source that is already pending merges with it, and the source is served only once.
- R10: A pending source whose mask bit is set before it is served is dropped without any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | 6 | One event pulse per source, bit i = source index i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| req_valid | output | 1 | Fixed-mode vector request, one cycle |
| req_vec | output | 8 | Vector of the request |
| req_src | output | 3 | Source index of the request |
| err_mode | output | 1 | Unsupported delivery-mode strobe, one cycle |
| err_src | output | 3 | Source index that caused the strobe |

## Verification
The assertions check the following on every cycle:
- a request and a strobe are never raised together;
- a strobe never names the timer or error source;
- a request never comes from a source that was masked when it was picked;
- with no pulse and nothing pending, the next cycle is silent.

Only the bench's scenarios can show the rest:
- that the correct vector reaches the output;
- the exact service order of simultaneous pulses;
- that a repeated pulse merges;
- that a pending source masked late is dropped;
- the register map, including ignored reserved bits and unmapped addresses.

// File: rtl/lvec_pkg.sv
package lvec_pkg;
    localparam int SRC_W    = 3;
    localparam int VEC_W    = 8;
    localparam int MODE_W   = 3;
    localparam int DATA_W   = 32;
    localparam int VEC_LSB  = 0;
    localparam int MODE_LSB = 8;
    localparam int MASK_POS = 16;

    localparam logic [MODE_W-1:0] MODE_FIXED = 3'd0;

    typedef struct packed {
        logic              mask;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vec;
    } lvt_entry_t;

    localparam lvt_entry_t ENTRY_RESET = '{mask: 1'b1, mode: MODE_FIXED, vec: '0};

    function automatic lvt_entry_t unpack_entry(input logic [DATA_W-1:0] w);
        lvt_entry_t e;
        e.vec  = w[VEC_LSB +: VEC_W];
        e.mode = w[MODE_LSB +: MODE_W];
        e.mask = w[MASK_POS];
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] pack_entry(input lvt_entry_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VEC_LSB +: VEC_W]   = e.vec;
        w[MODE_LSB +: MODE_W] = e.mode;
        w[MASK_POS]           = e.mask;
        return w;
    endfunction
endpackage

// File: rtl/lvec_regfile.sv
module lvec_regfile
    import lvec_pkg::*;
#(
    parameter int NSRC       = 6,
    parameter int ADDR_W     = 12,
    parameter int BASE_OFS   = 32'h320,
    parameter int STEP_SHIFT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output lvt_entry_t [NSRC-1:0]    ent_o,
    output logic [NSRC-1:0]          mask_o
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_OFS);

    typedef struct packed {
        lvt_entry_t [NSRC-1:0] ent;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [ADDR_W-1:0] ofs;
    logic              hit;
    logic [SRC_W-1:0]  idx;

    // Address decode: aligned slot inside the entry window
    always_comb begin
        ofs = addr - BASE_A;
        hit = (addr >= BASE_A) &&
              (ofs[STEP_SHIFT-1:0] == '0) &&
              ((ofs >> STEP_SHIFT) < ADDR_W'(NSRC));
        idx = SRC_W'(ofs >> STEP_SHIFT);
    end

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        if (hit) begin
            rdata = pack_entry(st_q.ent[idx]);
            if (wr_en) begin
                st_d.ent[idx] = unpack_entry(wdata);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                st_q.ent[i] <= ENTRY_RESET;
            end
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_out
        assign ent_o[g]  = st_q.ent[g];
        assign mask_o[g] = st_q.ent[g].mask;
    end
endmodule

// File: rtl/lvec_arbiter.sv
module lvec_arbiter
    import lvec_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pulse,
    input  logic [NSRC-1:0]  mask_vec,
    output logic             pick_valid,
    output logic [SRC_W-1:0] pick_idx,
    output logic [NSRC-1:0]  pend_o
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
    } arb_state_t;

    arb_state_t      st_d, st_q;
    logic [NSRC-1:0] eligible;
    logic [NSRC-1:0] grant;

    always_comb begin
        eligible   = (st_q.pend | pulse) & ~mask_vec;
        grant      = '0;
        pick_idx   = '0;
        pick_valid = |eligible;
        // Scan downwards so the lowest index is the last to win
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                pick_idx = SRC_W'(i);
            end
        end
        st_d.pend = eligible & ~grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/lvec_route.sv
module lvec_route
    import lvec_pkg::*;
#(
    parameter int              NSRC        = 6,
    parameter logic [NSRC-1:0] FORCE_FIXED = 6'b100001
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pick_valid,
    input  logic [SRC_W-1:0]      pick_idx,
    input  lvt_entry_t [NSRC-1:0] ent,
    output logic                  req_valid,
    output logic [VEC_W-1:0]      req_vec,
    output logic [SRC_W-1:0]      req_src,
    output logic                  err_mode,
    output logic [SRC_W-1:0]      err_src
);
    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
        logic [SRC_W-1:0] rsrc;
        logic             err;
        logic [SRC_W-1:0] esrc;
    } rt_state_t;

    rt_state_t                     st_d, st_q;
    logic [NSRC-1:0][MODE_W-1:0]   eff_mode;
    logic [MODE_W-1:0]             sel_mode;

    // Per-source effective mode: some sources ignore their mode field
    for (genvar g = 0; g < NSRC; g++) begin : g_mode
        if (FORCE_FIXED[g]) begin : g_forced
            assign eff_mode[g] = MODE_FIXED;
        end else begin : g_field
            assign eff_mode[g] = ent[g].mode;
        end
    end

    always_comb begin
        st_d     = '0;
        sel_mode = eff_mode[pick_idx];
        if (pick_valid) begin
            if (sel_mode == MODE_FIXED) begin
                st_d.req  = 1'b1;
                st_d.vec  = ent[pick_idx].vec;
                st_d.rsrc = pick_idx;
            end else begin
                st_d.err  = 1'b1;
                st_d.esrc = pick_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid = st_q.req;
    assign req_vec   = st_q.vec;
    assign req_src   = st_q.rsrc;
    assign err_mode  = st_q.err;
    assign err_src   = st_q.esrc;
endmodule

// File: rtl/lvec_dispatch.sv
module lvec_dispatch
    import lvec_pkg::*;
#(
    parameter int              NSRC        = 6,
    parameter int              ADDR_W      = 12,
    parameter int              BASE_OFS    = 32'h320,
    parameter int              STEP_SHIFT  = 4,
    parameter logic [NSRC-1:0] FORCE_FIXED = 6'b100001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    src_pulse,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               req_valid,
    output logic [VEC_W-1:0]   req_vec,
    output logic [SRC_W-1:0]   req_src,
    output logic               err_mode,
    output logic [SRC_W-1:0]   err_src
);
    lvt_entry_t [NSRC-1:0] ent;
    logic [NSRC-1:0]       mask_vec;
    logic [NSRC-1:0]       pend_q;
    logic                  pick_valid;
    logic [SRC_W-1:0]      pick_idx;

    lvec_regfile #(
        .NSRC(NSRC), .ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS), .STEP_SHIFT(STEP_SHIFT)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ent_o(ent), .mask_o(mask_vec)
    );

    lvec_arbiter #(.NSRC(NSRC)) arb_i (
        .clk(clk), .rst_n(rst_n), .pulse(src_pulse), .mask_vec(mask_vec),
        .pick_valid(pick_valid), .pick_idx(pick_idx), .pend_o(pend_q)
    );

    lvec_route #(.NSRC(NSRC), .FORCE_FIXED(FORCE_FIXED)) route_i (
        .clk(clk), .rst_n(rst_n), .pick_valid(pick_valid), .pick_idx(pick_idx),
        .ent(ent), .req_valid(req_valid), .req_vec(req_vec), .req_src(req_src),
        .err_mode(err_mode), .err_src(err_src)
    );
endmodule

// File: rtl/lvec_dispatch_chk.sv
module lvec_dispatch_chk
    import lvec_pkg::*;
#(
    parameter int NSRC = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSRC-1:0]  src_pulse,
    input logic [NSRC-1:0]  mask_vec,
    input logic [NSRC-1:0]  pend,
    input logic             req_valid,
    input logic [SRC_W-1:0] req_src,
    input logic             err_mode,
    input logic [SRC_W-1:0] err_src
);
    logic [NSRC-1:0] mask_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_prev <= '1;
        else        mask_prev <= mask_vec;
    end

    p_one_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && err_mode));

    p_forced_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |-> (err_src != SRC_W'(0) && err_src != SRC_W'(NSRC - 1)));

    p_src_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_src < SRC_W'(NSRC)));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pulse == '0 && pend == '0) |=> (!req_valid && !err_mode));

    p_no_masked_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !mask_prev[req_src]);
endmodule

bind lvec_dispatch lvec_dispatch_chk #(.NSRC(NSRC)) chk_i (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .mask_vec(mask_vec),
    .pend(pend_q), .req_valid(req_valid), .req_src(req_src),
    .err_mode(err_mode), .err_src(err_src)
);

// File: tb/lvec_dispatch_tb.sv
module lvec_dispatch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  src_pulse = '0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid, err_mode;
    logic [7:0]  req_vec;
    logic [2:0]  req_src, err_src;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    lvec_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_vec(req_vec), .req_src(req_src),
        .err_mode(err_mode), .err_src(err_src)
    );

    // {src, entry, exp_req, exp_err, exp_vec}
    typedef struct packed {
        logic [2:0]  src;
        logic [31:0] ent;
        logic        ereq;
        logic        eerr;
        logic [7:0]  evec;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 32'h0000_0041, 1'b1, 1'b0, 8'h41},
        '{3'd0, 32'h0000_0455, 1'b1, 1'b0, 8'h55},
        '{3'd1, 32'h0000_0033, 1'b1, 1'b0, 8'h33},
        '{3'd1, 32'h0000_0233, 1'b0, 1'b1, 8'h00},
        '{3'd2, 32'hFFFE_009A, 1'b1, 1'b0, 8'h9A},
        '{3'd3, 32'h0000_0510, 1'b0, 1'b1, 8'h00},
        '{3'd4, 32'h0000_07EE, 1'b0, 1'b1, 8'h00},
        '{3'd4, 32'h0000_00EE, 1'b1, 1'b0, 8'hEE},
        '{3'd5, 32'h0000_07C3, 1'b1, 1'b0, 8'hC3},
        '{3'd3, 32'h0001_0020, 1'b0, 1'b0, 8'h00},
        '{3'd5, 32'h0001_0444, 1'b0, 1'b0, 8'h00}
    };

    function automatic logic [13:0] obs();
        logic [2:0] s;
        s = req_valid ? req_src : (err_mode ? err_src : 3'd0);
        return {req_valid, err_mode, (req_valid ? req_vec : 8'h00), s};
    endfunction

    function automatic logic [13:0] expect_out(input logic r, input logic e,
                                               input logic [7:0] v, input logic [2:0] s);
        return {r, e, (r ? v : 8'h00), ((r | e) ? s : 3'd0)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [5:0] m);
        src_pulse = m;
        @(negedge clk);
        src_pulse = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 6; i++) begin
            rd(12'h320 + 12'(i * 16), d);
            chk("R1 reset entry", d, 32'h0001_0000);
        end
        chk("R1 idle outputs", {30'd0, req_valid, err_mode}, 32'd0);
        pulse(6'h3F);
        chk("R1 R3 masked after reset", {18'd0, obs()}, 32'd0);

        // R2: reserved bits, unmapped addresses
        wr(12'h330, 32'hFFFF_FFFF);
        rd(12'h330, d);
        chk("R2 reserved bits zero", d, 32'h0001_07FF);
        wr(12'h328, 32'h0000_0000);
        wr(12'h380, 32'h0000_0000);
        rd(12'h320, d);
        chk("R2 misaligned write ignored", d, 32'h0001_0000);
        rd(12'h370, d);
        chk("R2 write past window ignored", d, 32'h0001_0000);
        rd(12'h328, d);
        chk("R2 unmapped read", d, 32'h0);
        rd(12'h310, d);
        chk("R2 below window read", d, 32'h0);

        // Table walk: R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            wr(12'h320 + 12'({TBL[k].src, 4'h0}), TBL[k].ent);
            rd(12'h320 + 12'({TBL[k].src, 4'h0}), d);
            chk("R2 readback", d, TBL[k].ent & 32'h0001_07FF);
            pulse(6'b1 << TBL[k].src);
            chk("R3 R4 R5 R6 table outcome", {18'd0, obs()},
                {18'd0, expect_out(TBL[k].ereq, TBL[k].eerr, TBL[k].evec, TBL[k].src)});
            @(negedge clk);
            chk("R4 single cycle", {30'd0, req_valid, err_mode}, 32'd0);
        end

        // R7: simultaneous pulses served in index order
        for (int i = 0; i < 6; i++) wr(12'h320 + 12'(i * 16), 32'h0000_00A0 + 32'(i));
        pulse(6'h3F);
        for (int i = 0; i < 6; i++) begin
            chk("R7 service order", {18'd0, obs()},
                {18'd0, expect_out(1'b1, 1'b0, 8'hA0 + 8'(i), 3'(i))});
            @(negedge clk);
        end
        chk("R7 idle after burst", {18'd0, obs()}, 32'd0);

        // R10: pending source masked before service is dropped
        pulse(6'b010011);
        chk("R10 first served", {18'd0, obs()}, {18'd0, expect_out(1'b1, 1'b0, 8'hA0, 3'd0)});
        wr(12'h360, 32'h0001_00A4);
        chk("R10 second served", {18'd0, obs()}, {18'd0, expect_out(1'b1, 1'b0, 8'hA1, 3'd1)});
        @(negedge clk);
        chk("R10 masked pending dropped", {18'd0, obs()}, 32'd0);

        // R9: repeat pulse on a pending source merges
        src_pulse = 6'b001001;
        @(negedge clk);
        chk("R9 timer first", {18'd0, obs()}, {18'd0, expect_out(1'b1, 1'b0, 8'hA0, 3'd0)});
        src_pulse = 6'b001000;
        @(negedge clk);
        src_pulse = '0;
        chk("R9 pin0 served", {18'd0, obs()}, {18'd0, expect_out(1'b1, 1'b0, 8'hA3, 3'd3)});
        @(negedge clk);
        chk("R9 served only once", {18'd0, obs()}, 32'd0);

        // R5 R8: error strobe and request in consecutive cycles
        wr(12'h340, 32'h0000_04A2);
        pulse(6'b000101);
        chk("R8 timer request", {18'd0, obs()}, {18'd0, expect_out(1'b1, 1'b0, 8'hA0, 3'd0)});
        @(negedge clk);
        chk("R5 R8 perf strobe", {18'd0, obs()}, {18'd0, expect_out(1'b0, 1'b1, 8'h00, 3'd2)});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule